// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt events from sixteen peripheral sources and decides when the processor is to be interrupted. Each source holds a sticky request flag, a per-source enable and a two-bit urgency level written by software. A fixed-priority arbiter selects the most urgent pending, enabled source. That candidate is then compared with the processor's current interrupt level and its global interrupt enable. When the candidate is accepted, the block saves the return program counter, the other status flags, the current level and the global enable in a small internal frame stack. It then raises the current level to the accepted one and reports the source index as a vector.

A return strobe from the processor pops the most recent frame. The block reports the saved program counter and flags, and restores the level and enable that were in force before that frame was pushed, so nested handlers unwind in last-in, first-out order. Software can also load the current level and enable directly. This allows a handler to reopen nesting, and it is also how the frame stack can be filled to its limit.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A one on `src_event[n]` sets request flag n at the next clock edge. The flag stays set until `flag_clr[n]` or acceptance of source n clears it. When a set and a clear of the same flag fall in one cycle, the set wins.
- R2: A source competes for service only while both its request flag and its enable bit are 1. `en_we` loads all sixteen enable bits from `en_wdata`, and bit n enables source n.
- R3: Levels sit in four 8-bit registers chosen by `lvl_sel`. Source n uses register n/4, bits [2*(n%4)+1 : 2*(n%4)]. Value 1 is the most urgent and 2 is next. Value 3 keeps the source from ever being accepted. Value 0 behaves exactly as 1, and so does the level it installs.
- R4: After reset all flags and enables are 0, every level field is 3, the current level is 3, the global enable is 0, the frame stack is empty and every output pulse and the overflow flag are 0.
- R5: A candidate is accepted only when the global enable is 1 and its level value is strictly lower than the current level.
- R6: Among candidates, the lowest level value wins. Among equal levels, the lowest source index wins.
- R7: An acceptance decided in one cycle takes effect at the next edge. `irq_take` is high for one cycle with `irq_vec` holding the index. The current level becomes the accepted level, the source's flag is cleared, and a frame of {`pc_in`, `flags_in`, current level, global enable} is pushed.
- R8: `reti` with a non-empty stack pops the newest frame at the next edge. `ret_valid` then pulses for one cycle with `ret_pc` and `ret_flags` from that frame, and the saved level and enable are restored. With an empty stack, `reti` changes nothing.
- R9: In a cycle where `reti` is high, no acceptance takes place. A candidate that still qualifies is accepted in a later cycle.
- R10: A more urgent source preempts a running handler. A source whose level is not more urgent waits until the returns lower the current level far enough.
- R11: The stack holds 4 frames. An acceptance that finds it full is withheld and the request flag stays set. `ovf_err` is set and stays at 1 until reset.
- R12: `ps_we` loads the global enable from `ps_ie` and the current level from `ps_il` at the next edge. No acceptance takes place in a cycle where `ps_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_event | input | 16 | Per-source event pulses that set request flags |
| flag_clr | input | 16 | Per-source request flag clears |
| en_we | input | 1 | Load the enable bits |
| en_wdata | input | 16 | New enable bits |
| lvl_we | input | 1 | Write one level register |
| lvl_sel | input | 2 | Level register number |
| lvl_wdata | input | 8 | Four 2-bit level fields |
| ps_we | input | 1 | Load current level and global enable |
| ps_ie | input | 1 | New global enable |
| ps_il | input | 2 | New current level |
| reti | input | 1 | Return-from-interrupt strobe |
| pc_in | input | 16 | Return address to save on acceptance |
| flags_in | input | 6 | Other status flags to save on acceptance |
| req_flags | output | 16 | Request flags |
| cur_ie | output | 1 | Global interrupt enable |
| cur_il | output | 2 | Current interrupt level |
| irq_take | output | 1 | One-cycle acceptance pulse |
| irq_vec | output | 4 | Index of the last accepted source |
| ret_valid | output | 1 | One-cycle pulse when a frame was popped |
| ret_pc | output | 16 | Return address from the popped frame |
| ret_flags | output | 6 | Status flags from the popped frame |
| ovf_err | output | 1 | Sticky frame stack overflow flag |

## Verification
The first group of stimuli raises several sources in the same cycle with mixed levels. This shows whether the arbiter ranks by level before index and whether masked or disabled sources stay silent. A preempt-and-unwind sequence, using distinct saved addresses in each frame, reveals a stack that returns frames out of order or restores the wrong level. Collisions between a return strobe and a qualifying request, and between a status load and a qualifying request, show whether those cycles suppress acceptance. Filling the stack and then freeing one frame shows that the withheld request keeps its flag and is served as soon as space returns.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  parameter int unsigned LVL_W = 2;

  typedef logic [LVL_W-1:0] lvl_t;

  // level value that can never be accepted; also the idle program level
  localparam lvl_t LVL_MASKED = lvl_t'(3);
  localparam lvl_t LVL_IDLE   = lvl_t'(3);
  localparam lvl_t LVL_TOP    = lvl_t'(1);

  // field value 0 is handled as the most urgent usable level
  function automatic lvl_t norm_lvl(input lvl_t field);
    return (field == '0) ? LVL_TOP : field;
  endfunction

  // a candidate preempts only with a strictly smaller level value
  function automatic logic outranks(input lvl_t cand, input lvl_t cur);
    return cand < cur;
  endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned REG_W   = 8,
  localparam int unsigned FPR    = REG_W / LVL_W,
  localparam int unsigned NREG   = NUM_SRC / FPR,
  localparam int unsigned SEL_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       src_event,
  input  logic [NUM_SRC-1:0]       flag_clr,
  input  logic [NUM_SRC-1:0]       take_clr,
  input  logic                     en_we,
  input  logic [NUM_SRC-1:0]       en_wdata,
  input  logic                     lvl_we,
  input  logic [SEL_W-1:0]         lvl_sel,
  input  logic [REG_W-1:0]         lvl_wdata,
  output logic [NUM_SRC-1:0]       flags_q,
  output logic [NUM_SRC-1:0]       pend,
  output logic [NUM_SRC*LVL_W-1:0] lvl_flat
);

  logic [NUM_SRC-1:0] en_q;
  logic [REG_W-1:0]   lvl_reg [NREG];

  // event set dominates any clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= (flags_q & ~flag_clr & ~take_clr) | src_event;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        lvl_reg[r] <= '1;
      end
    end else if (lvl_we) begin
      lvl_reg[lvl_sel] <= lvl_wdata;
    end
  end

  assign pend = flags_q & en_q;

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
      assign lvl_flat[s*LVL_W +: LVL_W] = lvl_reg[s/FPR][(s%FPR)*LVL_W +: LVL_W];
    end
  endgenerate

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  output logic                     cand_valid,
  output logic [IDX_W-1:0]         cand_idx,
  output lvl_t                     cand_lvl
);

  lvl_t lv;

  // scan from the top index down; "<=" lets a lower index take over a tie
  always_comb begin
    cand_valid = 1'b0;
    cand_idx   = '0;
    cand_lvl   = LVL_IDLE;
    lv         = LVL_MASKED;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      lv = norm_lvl(lvl_flat[i*LVL_W +: LVL_W]);
      if (pend[i] && (lv != LVL_MASKED) && (lv <= cand_lvl)) begin
        cand_valid = 1'b1;
        cand_idx   = IDX_W'(i);
        cand_lvl   = lv;
      end
    end
  end

endmodule

// File: rtl/irq_save_stack.sv
module irq_save_stack #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned W      = 25,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt_m1;
  logic [AW-1:0]    wr_idx;
  logic [AW-1:0]    rd_idx;

  assign cnt_m1 = cnt - CNT_W'(1);
  assign wr_idx = cnt[AW-1:0];
  assign rd_idx = cnt_m1[AW-1:0];
  assign full   = (cnt == CNT_W'(DEPTH));
  assign empty  = (cnt == '0);
  assign dout   = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (pop && !empty) begin
      cnt <= cnt_m1;
    end else if (push && !full) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !pop && !full) begin
      mem[wr_idx] <= din;
    end
  end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 16,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned STK_DEPTH = 4,
  parameter int unsigned PC_W      = 16,
  parameter int unsigned FLG_W     = 6,
  localparam int unsigned IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned NREG     = NUM_SRC / (REG_W / LVL_W),
  localparam int unsigned SEL_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_event,
  input  logic [NUM_SRC-1:0] flag_clr,
  input  logic               en_we,
  input  logic [NUM_SRC-1:0] en_wdata,
  input  logic               lvl_we,
  input  logic [SEL_W-1:0]   lvl_sel,
  input  logic [REG_W-1:0]   lvl_wdata,
  input  logic               ps_we,
  input  logic               ps_ie,
  input  logic [LVL_W-1:0]   ps_il,
  input  logic               reti,
  input  logic [PC_W-1:0]    pc_in,
  input  logic [FLG_W-1:0]   flags_in,
  output logic [NUM_SRC-1:0] req_flags,
  output logic               cur_ie,
  output logic [LVL_W-1:0]   cur_il,
  output logic               irq_take,
  output logic [IDX_W-1:0]   irq_vec,
  output logic               ret_valid,
  output logic [PC_W-1:0]    ret_pc,
  output logic [FLG_W-1:0]   ret_flags,
  output logic               ovf_err
);

  localparam int unsigned FRAME_W = PC_W + FLG_W + LVL_W + 1;
  localparam int unsigned CNT_W   = $clog2(STK_DEPTH + 1);

  // named internal events, observed by the bound checker
  logic                     cand_valid;
  logic [IDX_W-1:0]         cand_idx;
  lvl_t                     cand_lvl;
  logic                     cand_ok;
  logic                     take_evt;
  logic                     ovf_evt;
  logic                     ret_evt;
  logic [NUM_SRC-1:0]       take_clr;
  logic [NUM_SRC-1:0]       pend;
  logic [NUM_SRC*LVL_W-1:0] lvl_flat;
  logic                     stk_full;
  logic                     stk_empty;
  logic [CNT_W-1:0]         stk_cnt;
  logic [FRAME_W-1:0]       push_frame;
  logic [FRAME_W-1:0]       top_frame;

  lvl_t cur_il_q;
  logic cur_ie_q;

  irq_src_bank #(
    .NUM_SRC (NUM_SRC),
    .REG_W   (REG_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_event (src_event),
    .flag_clr  (flag_clr),
    .take_clr  (take_clr),
    .en_we     (en_we),
    .en_wdata  (en_wdata),
    .lvl_we    (lvl_we),
    .lvl_sel   (lvl_sel),
    .lvl_wdata (lvl_wdata),
    .flags_q   (req_flags),
    .pend      (pend),
    .lvl_flat  (lvl_flat)
  );

  irq_arbiter #(
    .NUM_SRC (NUM_SRC)
  ) u_arb (
    .pend       (pend),
    .lvl_flat   (lvl_flat),
    .cand_valid (cand_valid),
    .cand_idx   (cand_idx),
    .cand_lvl   (cand_lvl)
  );

  // a return strobe and a status load each claim the cycle for themselves
  assign ret_evt  = reti && !stk_empty;
  assign cand_ok  = cand_valid && cur_ie_q && outranks(cand_lvl, cur_il_q)
                    && !reti && !ps_we;
  assign take_evt = cand_ok && !stk_full;
  assign ovf_evt  = cand_ok && stk_full;
  assign take_clr = take_evt ? (NUM_SRC'(1) << cand_idx) : '0;

  assign push_frame = {cur_ie_q, cur_il_q, flags_in, pc_in};

  irq_save_stack #(
    .DEPTH (STK_DEPTH),
    .W     (FRAME_W)
  ) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (take_evt),
    .pop   (ret_evt),
    .din   (push_frame),
    .dout  (top_frame),
    .cnt   (stk_cnt),
    .full  (stk_full),
    .empty (stk_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ie_q <= 1'b0;
      cur_il_q <= LVL_IDLE;
    end else if (ret_evt) begin
      cur_ie_q <= top_frame[FRAME_W-1];
      cur_il_q <= top_frame[PC_W+FLG_W +: LVL_W];
    end else if (ps_we) begin
      cur_ie_q <= ps_ie;
      cur_il_q <= ps_il;
    end else if (take_evt) begin
      cur_il_q <= cand_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_take  <= 1'b0;
      irq_vec   <= '0;
      ret_valid <= 1'b0;
      ret_pc    <= '0;
      ret_flags <= '0;
      ovf_err   <= 1'b0;
    end else begin
      irq_take  <= take_evt;
      ret_valid <= ret_evt;
      ovf_err   <= ovf_err | ovf_evt;
      if (take_evt) begin
        irq_vec <= cand_idx;
      end
      if (ret_evt) begin
        ret_pc    <= top_frame[PC_W-1:0];
        ret_flags <= top_frame[PC_W +: FLG_W];
      end
    end
  end

  assign cur_ie = cur_ie_q;
  assign cur_il = cur_il_q;

endmodule

// File: rtl/nest_irq_chk.sv
module nest_irq_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3,
  parameter int unsigned LV_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_take,
  input logic             ret_valid,
  input logic             cur_ie,
  input logic [LV_W-1:0]  cur_il,
  input logic             ovf_err,
  input logic [CNT_W-1:0] stk_cnt
);

  AST_TAKE_MORE_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (cur_il < $past(cur_il))); // R5

  AST_TAKE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(cur_ie)); // R5

  AST_TAKE_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (stk_cnt == CNT_W'($past(stk_cnt) + 1'b1))); // R7

  AST_RET_HAS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> ($past(stk_cnt) != '0)); // R8

  AST_RET_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (stk_cnt == CNT_W'($past(stk_cnt) - 1'b1))); // R8

  AST_RET_EXCLUDES_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_take && ret_valid)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    stk_cnt <= CNT_W'(DEPTH)); // R11

  AST_FULL_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_cnt == CNT_W'(DEPTH)) |=> !irq_take); // R11

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R11

endmodule

bind nest_irq_ctrl nest_irq_chk #(
  .DEPTH (STK_DEPTH),
  .CNT_W ($clog2(STK_DEPTH + 1)),
  .LV_W  (irq_nest_pkg::LVL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_take  (irq_take),
  .ret_valid (ret_valid),
  .cur_ie    (cur_ie),
  .cur_il    (cur_il),
  .ovf_err   (ovf_err),
  .stk_cnt   (stk_cnt)
);

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
module nest_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_event, flag_clr, en_wdata;
  logic        en_we, lvl_we, ps_we, ps_ie, reti;
  logic [1:0]  lvl_sel, ps_il;
  logic [7:0]  lvl_wdata;
  logic [15:0] pc_in;
  logic [5:0]  flags_in;
  logic [15:0] req_flags;
  logic        cur_ie, irq_take, ret_valid, ovf_err;
  logic [1:0]  cur_il;
  logic [3:0]  irq_vec;
  logic [15:0] ret_pc;
  logic [5:0]  ret_flags;

  int tests = 0;
  int fails = 0;
  logic [1:0] shadow [16];

  always #2.5 clk = ~clk;

  nest_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_event(src_event), .flag_clr(flag_clr),
    .en_we(en_we), .en_wdata(en_wdata), .lvl_we(lvl_we), .lvl_sel(lvl_sel),
    .lvl_wdata(lvl_wdata), .ps_we(ps_we), .ps_ie(ps_ie), .ps_il(ps_il),
    .reti(reti), .pc_in(pc_in), .flags_in(flags_in), .req_flags(req_flags),
    .cur_ie(cur_ie), .cur_il(cur_il), .irq_take(irq_take), .irq_vec(irq_vec),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_flags(ret_flags),
    .ovf_err(ovf_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src_event = '0; flag_clr = '0; en_we = 1'b0; en_wdata = '0;
    lvl_we = 1'b0; lvl_sel = '0; lvl_wdata = '0; ps_we = 1'b0; ps_ie = 1'b0;
    ps_il = '0; reti = 1'b0; pc_in = '0; flags_in = '0;
    for (int i = 0; i < 16; i++) shadow[i] = 2'd3;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic pulse_ev(input logic [15:0] m);
    src_event = m; tick(); src_event = '0;
  endtask

  task automatic wr_en(input logic [15:0] m);
    en_we = 1'b1; en_wdata = m; tick(); en_we = 1'b0;
  endtask

  task automatic set_lvl(input int src, input logic [1:0] v);
    int r;
    r = src / 4;
    shadow[src] = v;
    lvl_we = 1'b1; lvl_sel = 2'(r);
    lvl_wdata = {shadow[4*r+3], shadow[4*r+2], shadow[4*r+1], shadow[4*r]};
    tick(); lvl_we = 1'b0;
  endtask

  task automatic wr_ps(input logic ie, input logic [1:0] il);
    ps_we = 1'b1; ps_ie = ie; ps_il = il; tick(); ps_we = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R4 cur_il", 32'(cur_il), 3);
    chk("R4 cur_ie", 32'(cur_ie), 0);
    chk("R4 flags", 32'(req_flags), 0);
    chk("R4 take", 32'(irq_take), 0);
    chk("R4 ovf", 32'(ovf_err), 0);
    wr_en(16'hFFFF);
    wr_ps(1'b1, 2'd3);
    pulse_ev(16'hFFFF);
    tick(); tick();
    chk("R4 default levels masked", 32'(irq_take), 0);
    chk("R4 level unchanged", 32'(cur_il), 3);
  endtask

  task automatic t_flags();
    do_reset();
    wr_ps(1'b1, 2'd3);
    chk("R12 ps load", 32'({cur_ie, cur_il}), 32'h7);
    set_lvl(5, 2'd1);
    pulse_ev(16'h0020);
    chk("R1 flag set", 32'(req_flags[5]), 1);
    tick(); tick(); tick();
    chk("R1 flag held", 32'(req_flags[5]), 1);
    chk("R2 disabled no take", 32'(irq_take), 0);
    flag_clr = 16'h0020; tick(); flag_clr = '0;
    chk("R1 flag cleared", 32'(req_flags[5]), 0);
    src_event = 16'h0020; flag_clr = 16'h0020; tick();
    src_event = '0; flag_clr = '0;
    chk("R1 set beats clear", 32'(req_flags[5]), 1);
    wr_en(16'h0020);
    tick();
    chk("R2 enabled take", 32'(irq_take), 1);
    chk("R7 vec", 32'(irq_vec), 5);
    chk("R7 flag cleared on take", 32'(req_flags[5]), 0);
    chk("R7 level raised", 32'(cur_il), 1);
  endtask

  task automatic t_levels();
    do_reset();
    wr_ps(1'b1, 2'd3);
    wr_en(16'h00F0);
    set_lvl(6, 2'd2);
    pulse_ev(16'h00F0);
    tick();
    chk("R3 field mapping take", 32'(irq_take), 1);
    chk("R3 field mapping vec", 32'(irq_vec), 6);
    chk("R3 level 2 installed", 32'(cur_il), 2);
    tick();
    chk("R3 level 3 masked", 32'(irq_take), 0);
    do_reset();
    wr_ps(1'b1, 2'd2);
    set_lvl(11, 2'd0);
    wr_en(16'h0800);
    pulse_ev(16'h0800);
    tick();
    chk("R3 zero acts as 1 take", 32'(irq_take), 1);
    chk("R3 zero installs 1", 32'(cur_il), 1);
  endtask

  task automatic t_gate();
    do_reset();
    set_lvl(4, 2'd1);
    wr_en(16'h0010);
    pulse_ev(16'h0010);
    tick(); tick();
    chk("R5 ie=0 blocks", 32'(irq_take), 0);
    wr_ps(1'b1, 2'd1);
    tick();
    chk("R5 equal level blocks", 32'(irq_take), 0);
    wr_ps(1'b1, 2'd2);
    tick();
    chk("R5 strictly lower accepted", 32'(irq_take), 1);
    chk("R5 vec", 32'(irq_vec), 4);
  endtask

  task automatic t_ps_block();
    do_reset();
    set_lvl(8, 2'd1);
    wr_en(16'h0100);
    pulse_ev(16'h0100);
    ps_we = 1'b1; ps_ie = 1'b1; ps_il = 2'd3;
    tick(); tick();
    chk("R12 ps_we suppresses take", 32'(irq_take), 0);
    ps_we = 1'b0;
    tick();
    chk("R12 take after ps_we drops", 32'(irq_take), 1);
  endtask

  task automatic t_prio();
    do_reset();
    wr_ps(1'b1, 2'd3);
    set_lvl(3, 2'd2); set_lvl(9, 2'd2); set_lvl(12, 2'd1); set_lvl(14, 2'd1);
    wr_en(16'h5208);
    pulse_ev(16'h5208);
    tick();
    chk("R6 level1 low index first", 32'(irq_vec), 12);
    chk("R6 take", 32'(irq_take), 1);
    do_reti(); tick();
    chk("R6 second level1", 32'(irq_vec), 14);
    do_reti(); tick();
    chk("R6 level2 low index", 32'(irq_vec), 3);
    chk("R6 level2 installed", 32'(cur_il), 2);
    do_reti(); tick();
    chk("R6 last level2", 32'(irq_vec), 9);
  endtask

  task automatic t_nest();
    do_reset();
    wr_ps(1'b1, 2'd3);
    set_lvl(2, 2'd2); set_lvl(7, 2'd1);
    wr_en(16'h0084);
    pc_in = 16'h0100; flags_in = 6'h05;
    pulse_ev(16'h0004); tick();
    chk("R7 outer take", 32'(irq_vec), 2);
    pc_in = 16'h0200; flags_in = 6'h0A;
    pulse_ev(16'h0080); tick();
    chk("R10 preempt take", 32'(irq_take), 1);
    chk("R10 preempt vec", 32'(irq_vec), 7);
    chk("R10 level 1", 32'(cur_il), 1);
    pulse_ev(16'h0004); tick(); tick();
    chk("R10 less urgent waits", 32'(irq_take), 0);
    do_reti();
    chk("R8 ret valid", 32'(ret_valid), 1);
    chk("R8 ret pc inner", 32'(ret_pc), 32'h0200);
    chk("R8 ret flags inner", 32'(ret_flags), 32'h0A);
    chk("R8 level restored 2", 32'(cur_il), 2);
    tick();
    chk("R10 still waits at level 2", 32'(irq_take), 0);
    do_reti();
    chk("R8 ret pc outer", 32'(ret_pc), 32'h0100);
    chk("R8 ret flags outer", 32'(ret_flags), 32'h05);
    chk("R8 idle restored", 32'({cur_ie, cur_il}), 32'h7);
    tick();
    chk("R10 waiting source served", 32'(irq_take), 1);
    chk("R10 waiting vec", 32'(irq_vec), 2);
  endtask

  task automatic t_same();
    do_reset();
    wr_ps(1'b1, 2'd3);
    set_lvl(1, 2'd1);
    wr_en(16'h0002);
    pulse_ev(16'h0002); tick();
    chk("R9 first take", 32'(irq_take), 1);
    wr_ps(1'b1, 2'd3);
    src_event = 16'h0002; tick(); src_event = '0;
    reti = 1'b1; tick(); reti = 1'b0;
    chk("R9 reti wins", 32'(ret_valid), 1);
    chk("R9 no take with reti", 32'(irq_take), 0);
    tick();
    chk("R9 deferred take", 32'(irq_take), 1);
  endtask

  task automatic t_empty();
    do_reset();
    do_reti();
    chk("R8 empty reti no pulse", 32'(ret_valid), 0);
    chk("R8 empty reti state", 32'({cur_ie, cur_il}), 32'h3);
    wr_ps(1'b1, 2'd2);
    do_reti();
    chk("R8 empty reti keeps loaded", 32'({cur_ie, cur_il}), 32'h6);
  endtask

  task automatic t_ovf();
    do_reset();
    wr_ps(1'b1, 2'd3);
    set_lvl(0, 2'd1);
    wr_en(16'h0001);
    for (int k = 0; k < 4; k++) begin
      pc_in = 16'h1000 + 16'(k);
      pulse_ev(16'h0001); tick();
      chk("R11 fill take", 32'(irq_take), 1);
      wr_ps(1'b1, 2'd3);
    end
    chk("R11 no error yet", 32'(ovf_err), 0);
    pc_in = 16'h2000;
    pulse_ev(16'h0001); tick(); tick();
    chk("R11 full withholds", 32'(irq_take), 0);
    chk("R11 error set", 32'(ovf_err), 1);
    chk("R11 flag kept", 32'(req_flags[0]), 1);
    do_reti();
    chk("R11 newest frame", 32'(ret_pc), 32'h1003);
    tick();
    chk("R11 served after pop", 32'(irq_take), 1);
    tick();
    chk("R11 error sticky", 32'(ovf_err), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_flags();
    t_levels();
    t_gate();
    t_ps_block();
    t_prio();
    t_nest();
    t_same();
    t_empty();
    t_ovf();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule